// File: doc/BRIEF.md
# Display Raster Timing Controller

This block produces the timing skeleton of a progressive video raster: horizontal and vertical sync, horizontal and vertical active windows, a data-enable strobe, a one-clock end-of-frame marker and an early fetch trigger that starts memory reads before pixels are needed. Each line is laid out as active pixels, then front porch, then the sync pulse, then back porch. Each frame is laid out the same way in lines. All of these lengths are parameters, as are the fetch lead time and the sync polarity.

Two independent position counters are kept. Each is a horizontal and vertical pair. The fetch pair starts as soon as the block is enabled, and only the fetch trigger is decoded from it. The display pair drives every other timing output. When external alignment is off, the display pair starts with the enable, in step with the fetch pair. When external alignment is on, the display pair waits at position zero for a reference pulse. This pulse would normally be the fetch timing after it has passed through the downstream pixel pipeline. Because the display pair starts on it, the sync outputs line up with the delayed pixel data. A 16-bit output reports the configured active width. The counters are sized from the parameters and cover rasters up to 4096 × 2160.

Top module: `raster_timing_ctrl`

## Requirements
- R1: `rst_n` is active low and asynchronous. While it is low, every output is at its inactive level. Both syncs sit at the opposite of the active sync level, and `h_active`, `v_active`, `data_en`, `frame_end` and `fetch_trig` are 0. This takes effect without waiting for a clock edge.
- R2: The fetch pair starts on the first rising clock edge that samples `enable` high. The output after that edge shows horizontal position 0. The horizontal position then advances by one per clock and returns to 0 after H_ACT+H_FP+H_SYNC+H_BP−1.
- R3: The vertical position of each pair advances only when that pair finishes a line. It returns to 0 after V_ACT+V_FP+V_SYNC+V_BP−1 lines. Position n clocks after a pair starts is line (n / line total) mod frame total.
- R4: `fetch_trig` is a one-clock pulse, taken from the fetch pair. It fires at horizontal position line total − TRIG_LEAD on every line whose following line (wrapping at the frame total) is an active line. That gives V_ACT pulses per frame, each TRIG_LEAD clocks before an active line starts.
- R5: With `ext_sync_en` low, the display pair starts on the same edge as the fetch pair. The timing outputs then follow the fetch position exactly.
- R6: With `ext_sync_en` high, the display pair stays at position 0 and its outputs stay inactive until an edge samples `ext_sync_ref` high. The output after that edge shows position 0. Later pulses on `ext_sync_ref` have no effect until `enable` is next deasserted.
- R7: Take display-pair position h, v. Then `h_active` is high for h < H_ACT and `v_active` is high for v < V_ACT. `hsync` is at the active level for H_ACT+H_FP ≤ h < H_ACT+H_FP+H_SYNC. `vsync` is at the active level for the same window built from the vertical lengths. The active level is high when SYNC_HIGH is 1 and low when it is 0.
- R8: `data_en` is high exactly when `h_active` and `v_active` are both high.
- R9: `frame_end` is high for exactly one clock per frame, while the display outputs show the last position of the frame.
- R10: Deasserting `enable` clears both pairs. On the next clock every output goes to its inactive level. When `enable` is asserted again, both pairs restart from position 0 under R2, R5 and R6.
- R11: `h_res` always equals H_ACT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run both position counters; low clears them |
| ext_sync_en | input | 1 | Start the display pair from `ext_sync_ref` instead of `enable` |
| ext_sync_ref | input | 1 | Reference pulse that starts the display pair |
| hsync | output | 1 | Horizontal sync at the polarity set by SYNC_HIGH |
| vsync | output | 1 | Vertical sync at the polarity set by SYNC_HIGH |
| h_active | output | 1 | Inside the active part of a line |
| v_active | output | 1 | Inside the active lines of a frame |
| data_en | output | 1 | Active pixel strobe |
| frame_end | output | 1 | One-clock pulse on the last position of a frame |
| fetch_trig | output | 1 | Early pulse ahead of each active line, for memory reads |
| h_res | output | 16 | Configured active width |

## Verification
The embedded properties check several rules on every clock. The horizontal count stays within the line total, and the vertical count moves only at a line end, by exactly one. Disabling the block clears both pairs. With alignment off, the two pairs restart together. A waiting display pair stays at zero. `data_en` always matches the two active flags, and `frame_end` and `fetch_trig` never last two clocks. Other behaviour depends on the exact position of each pulse. This covers the window edges, the vertical wrap, which lines carry a trigger, the offset set by the reference pulse, the fact that later reference pulses are ignored, and how fast reset and disable take effect. Only the bench scenarios can show these, because they compare every output on every cycle against positions derived from when the stimulus was applied.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Width of the reported active-width field.
  localparam int unsigned RES_W = 16;

  // Registered display-side timing flags.
  typedef struct packed {
    logic hsync;
    logic vsync;
    logic h_act;
    logic v_act;
    logic de;
    logic fend;
  } raster_out_t;

endpackage

// File: rtl/raster_counter.sv
// One horizontal/vertical position pair with a start qualifier.
module raster_counter #(
  parameter int unsigned H_TOTAL = 2200,
  parameter int unsigned V_TOTAL = 1125,
  localparam int unsigned HW = $clog2(H_TOTAL),
  localparam int unsigned VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          start,
  output logic          live,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  logic          run_q, run_d;
  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          line_end;
  logic          upd;

  assign live     = enable & (run_q | start);
  assign line_end = (h_q == H_LAST);
  // Clock enable: registers change only while running or when clearing.
  assign upd      = live | ~enable;

  always_comb begin
    run_d = run_q;
    h_d   = h_q;
    v_d   = v_q;
    if (!enable) begin
      run_d = 1'b0;
      h_d   = '0;
      v_d   = '0;
    end else if (live) begin
      run_d = 1'b1;
      if (line_end) begin
        h_d = '0;
        v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
      end else begin
        h_d = h_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      h_q   <= '0;
      v_q   <= '0;
    end else if (upd) begin
      run_q <= run_d;
      h_q   <= h_d;
      v_q   <= v_d;
    end
  end

  assign hcnt = h_q;
  assign vcnt = v_q;

  assert_hrange_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(h_q) < H_TOTAL);

  assert_vhold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !line_end) |=> $stable(v_q));

  assert_vstep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && line_end && (v_q != V_LAST)) |=> (v_q == $past(v_q) + 1'b1));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (h_q == '0 && v_q == '0 && !run_q));

endmodule

// File: rtl/fetch_trigger.sv
// Early read trigger decoded from the free-running pair.
module fetch_trigger #(
  parameter int unsigned H_TOTAL  = 2200,
  parameter int unsigned V_TOTAL  = 1125,
  parameter int unsigned V_ACT    = 1080,
  parameter int unsigned LEAD     = 64,
  localparam int unsigned HW = $clog2(H_TOTAL),
  localparam int unsigned VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  output logic          trig
);

  localparam logic [HW-1:0] H_FIRE = HW'(H_TOTAL - LEAD);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_ACTL = VW'(V_ACT);

  logic [VW-1:0] v_next;
  logic          trig_d, trig_q;

  always_comb begin
    v_next = (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
    trig_d = live && (hcnt == H_FIRE) && (v_next < V_ACTL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

  assign trig = trig_q;

  assert_trig_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q);

endmodule

// File: rtl/timing_decode.sv
// Registered window and sync decode for the display pair.
module timing_decode
  import raster_pkg::*;
#(
  parameter int unsigned H_ACT     = 1920,
  parameter int unsigned H_FP      = 88,
  parameter int unsigned H_SYNC    = 44,
  parameter int unsigned H_BP      = 148,
  parameter int unsigned V_ACT     = 1080,
  parameter int unsigned V_FP      = 4,
  parameter int unsigned V_SYNC    = 5,
  parameter int unsigned V_BP      = 36,
  parameter int unsigned SYNC_HIGH = 1,
  localparam int unsigned H_TOTAL = H_ACT + H_FP + H_SYNC + H_BP,
  localparam int unsigned V_TOTAL = V_ACT + V_FP + V_SYNC + V_BP,
  localparam int unsigned HW = $clog2(H_TOTAL),
  localparam int unsigned VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  output raster_out_t   flags
);

  localparam logic SYNC_ON = (SYNC_HIGH != 0);
  localparam logic [HW-1:0] H_ACT_L = HW'(H_ACT);
  localparam logic [HW-1:0] H_SB    = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] H_SE    = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_ACT_L = VW'(V_ACT);
  localparam logic [VW-1:0] V_SB    = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] V_SE    = VW'(V_ACT + V_FP + V_SYNC);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);

  localparam raster_out_t IDLE = '{hsync: ~SYNC_ON, vsync: ~SYNC_ON,
                                   h_act: 1'b0, v_act: 1'b0, de: 1'b0, fend: 1'b0};

  raster_out_t flags_d, flags_q;
  logic        hs_win, vs_win;

  always_comb begin
    hs_win  = (hcnt >= H_SB) && (hcnt < H_SE);
    vs_win  = (vcnt >= V_SB) && (vcnt < V_SE);
    flags_d = IDLE;
    if (live) begin
      flags_d.h_act = (hcnt < H_ACT_L);
      flags_d.v_act = (vcnt < V_ACT_L);
      flags_d.hsync = hs_win ? SYNC_ON : ~SYNC_ON;
      flags_d.vsync = vs_win ? SYNC_ON : ~SYNC_ON;
      flags_d.de    = flags_d.h_act & flags_d.v_act;
      flags_d.fend  = (hcnt == H_LAST) && (vcnt == V_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= IDLE;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

  assert_de_and_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.de == (flags_q.h_act && flags_q.v_act));

  assert_fend_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.fend |=> !flags_q.fend);

endmodule

// File: rtl/raster_timing_ctrl.sv
// Dual-pair raster timing controller (top).
module raster_timing_ctrl
  import raster_pkg::*;
#(
  parameter int unsigned H_ACT     = 1920,
  parameter int unsigned H_FP      = 88,
  parameter int unsigned H_SYNC    = 44,
  parameter int unsigned H_BP      = 148,
  parameter int unsigned V_ACT     = 1080,
  parameter int unsigned V_FP      = 4,
  parameter int unsigned V_SYNC    = 5,
  parameter int unsigned V_BP      = 36,
  parameter int unsigned TRIG_LEAD = 64,
  parameter int unsigned SYNC_HIGH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ext_sync_en,
  input  logic             ext_sync_ref,
  output logic             hsync,
  output logic             vsync,
  output logic             h_active,
  output logic             v_active,
  output logic             data_en,
  output logic             frame_end,
  output logic             fetch_trig,
  output logic [RES_W-1:0] h_res
);

  localparam int unsigned H_TOTAL = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int unsigned V_TOTAL = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int unsigned HW      = $clog2(H_TOTAL);
  localparam int unsigned VW      = $clog2(V_TOTAL);
  localparam int unsigned NPAIR   = 2;   // 0: fetch pair, 1: display pair

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [NPAIR-1:0] start_v;
  logic [NPAIR-1:0] live_v;
  logic [HW-1:0]    h_v [NPAIR];
  logic [VW-1:0]    v_v [NPAIR];

  assign start_v[0] = 1'b1;
  assign start_v[1] = ext_sync_en ? ext_sync_ref : 1'b1;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    raster_counter #(
      .H_TOTAL (H_TOTAL),
      .V_TOTAL (V_TOTAL)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .enable (enable),
      .start  (start_v[g]),
      .live   (live_v[g]),
      .hcnt   (h_v[g]),
      .vcnt   (v_v[g])
    );
  end

  fetch_trigger #(
    .H_TOTAL (H_TOTAL),
    .V_TOTAL (V_TOTAL),
    .V_ACT   (V_ACT),
    .LEAD    (TRIG_LEAD)
  ) u_trig (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .live  (live_v[0]),
    .hcnt  (h_v[0]),
    .vcnt  (v_v[0]),
    .trig  (fetch_trig)
  );

  raster_out_t disp;

  timing_decode #(
    .H_ACT (H_ACT), .H_FP (H_FP), .H_SYNC (H_SYNC), .H_BP (H_BP),
    .V_ACT (V_ACT), .V_FP (V_FP), .V_SYNC (V_SYNC), .V_BP (V_BP),
    .SYNC_HIGH (SYNC_HIGH)
  ) u_dec (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .live  (live_v[1]),
    .hcnt  (h_v[1]),
    .vcnt  (v_v[1]),
    .flags (disp)
  );

  assign hsync     = disp.hsync;
  assign vsync     = disp.vsync;
  assign h_active  = disp.h_act;
  assign v_active  = disp.v_act;
  assign data_en   = disp.de;
  assign frame_end = disp.fend;
  assign h_res     = RES_W'(H_ACT);

  assert_lockstep_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(enable) && !ext_sync_en) |=> (h_v[0] == h_v[1] && v_v[0] == v_v[1]));

  assert_wait_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ext_sync_en && enable && !live_v[1]) |=> (h_v[1] == '0 && v_v[1] == '0));

endmodule

// File: tb/raster_timing_ctrl_test.sv
module raster_timing_ctrl_test;

  localparam int HA = 8, HF = 2, HS = 3, HB = 3;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;   // 16
  localparam int VT = VA + VF + VS + VB;   // 8
  localparam int FRAME = HT * VT;          // 128
  localparam int LEAD = 3;
  localparam bit POL = 1'b0;               // active-low sync

  logic clk = 1'b0;
  logic rst_n, enable, ext_sync_en, ext_sync_ref;
  logic hsync, vsync, h_active, v_active, data_en, frame_end, fetch_trig;
  logic [15:0] h_res;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  raster_timing_ctrl #(
    .H_ACT (HA), .H_FP (HF), .H_SYNC (HS), .H_BP (HB),
    .V_ACT (VA), .V_FP (VF), .V_SYNC (VS), .V_BP (VB),
    .TRIG_LEAD (LEAD), .SYNC_HIGH (POL)
  ) uut (
    .clk (clk), .rst_n (rst_n), .enable (enable),
    .ext_sync_en (ext_sync_en), .ext_sync_ref (ext_sync_ref),
    .hsync (hsync), .vsync (vsync), .h_active (h_active), .v_active (v_active),
    .data_en (data_en), .frame_end (frame_end), .fetch_trig (fetch_trig),
    .h_res (h_res)
  );

  // Expected {hsync,vsync,h_active,v_active,data_en,frame_end,fetch_trig}.
  // p1 / p2: clocks since fetch / display pair started, negative = idle.
  function automatic logic [6:0] expect_vec(int p1, int p2);
    logic hs, vs, ha, va, fe, tr;
    int h, v, nv;
    hs = ~POL; vs = ~POL; ha = 1'b0; va = 1'b0; fe = 1'b0; tr = 1'b0;
    if (p2 >= 0) begin
      h  = p2 % HT;
      v  = (p2 / HT) % VT;
      ha = (h < HA);
      va = (v < VA);
      hs = (h >= HA + HF && h < HA + HF + HS) ? POL : ~POL;
      vs = (v >= VA + VF && v < VA + VF + VS) ? POL : ~POL;
      fe = (h == HT - 1) && (v == VT - 1);
    end
    if (p1 >= 0) begin
      h  = p1 % HT;
      v  = (p1 / HT) % VT;
      nv = (v + 1) % VT;
      tr = (h == HT - LEAD) && (nv < VA);
    end
    return {hs, vs, ha, va, ha & va, fe, tr};
  endfunction

  task automatic check_vec(string tag, int n, logic [6:0] exp_v);
    logic [6:0] got;
    got = {hsync, vsync, h_active, v_active, data_en, frame_end, fetch_trig};
    tests++;
    if (got !== exp_v) begin
      fails++;
      $display("FAIL %s cycle %0d: got %b expected %b", tag, n, got, exp_v);
    end
  endtask

  task automatic check_val(string tag, int got, int exp_v);
    tests++;
    if (got != exp_v) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp_v);
    end
  endtask

  // R1, R11: outputs while reset is held.
  task automatic t_reset;
    rst_n = 1'b0; enable = 1'b0; ext_sync_en = 1'b0; ext_sync_ref = 1'b0;
    repeat (3) @(negedge clk);
    check_vec("R1 reset", 0, expect_vec(-1, -1));
    check_val("R11 h_res", int'(h_res), HA);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_vec("R1 idle after reset", 0, expect_vec(-1, -1));
  endtask

  // R2 R3 R4 R5 R7 R8 R9: both pairs started by enable, two frames plus.
  task automatic t_free_run;
    int trigs = 0, fends = 0;
    ext_sync_en = 1'b0;
    enable = 1'b1;
    for (int n = 0; n < 2 * FRAME + 20; n++) begin
      @(negedge clk);
      check_vec("R2 R3 R4 R5 R7 R8 R9 free", n, expect_vec(n, n));
      if (n < FRAME) begin
        trigs += int'(fetch_trig);
        fends += int'(frame_end);
      end
    end
    check_val("R4 triggers per frame", trigs, VA);
    check_val("R9 frame ends per frame", fends, 1);
  endtask

  // R10: disable mid frame, then restart from position 0.
  task automatic t_disable;
    enable = 1'b0;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      check_vec("R10 disabled", n, expect_vec(-1, -1));
    end
    enable = 1'b1;
    for (int n = 0; n < HT + 4; n++) begin
      @(negedge clk);
      check_vec("R10 restart", n, expect_vec(n, n));
    end
    enable = 1'b0;
    @(negedge clk);
    check_vec("R10 disabled again", 0, expect_vec(-1, -1));
  endtask

  // R6: display pair waits for reference, later pulses ignored.
  task automatic t_ext_sync;
    localparam int D = 5;
    ext_sync_en = 1'b1;
    ext_sync_ref = 1'b0;
    enable = 1'b1;
    for (int n = 0; n < FRAME + D + 24; n++) begin
      @(negedge clk);
      check_vec("R6 external start", n, expect_vec(n, (n >= D) ? n - D : -1));
      ext_sync_ref = (n == D - 1) || (n == 40) || (n == 41);
    end
    enable = 1'b0;
    @(negedge clk);
    check_vec("R10 disabled ext", 0, expect_vec(-1, -1));
    ext_sync_en = 1'b0;
  endtask

  // R1: reset takes effect between clock edges.
  task automatic t_async_reset;
    enable = 1'b1;
    repeat (HA / 2) @(negedge clk);
    check_vec("R1 running before reset", 0, expect_vec(HA / 2 - 1, HA / 2 - 1));
    #2 rst_n = 1'b0;
    #1 check_vec("R1 asynchronous", 0, expect_vec(-1, -1));
    @(negedge clk);
    enable = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_val("R11 h_res after reset", int'(h_res), HA);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_free_run();
    t_disable();
    t_ext_sync();
    t_async_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule